// File: doc/BRIEF.md
# Bus Initiator Sequencer with Master Abort

This block drives the initiator-side control strobes of a PCI-style multiplexed bus for a single transaction. It opens an access by pulling FRAME# low for one address clock and then asserts IRDY# for the data phases. It counts completed data phases against a requested burst length. It watches the target's DEVSEL#, TRDY# and STOP# to decide when to close the access. If no target claims the access within five data clocks, it closes the access as a master abort. Address, data, parity and bus arbitration are handled elsewhere.

The local side presents a burst length and a write/read flag together with a one-clock start request. While a transaction runs, a busy flag is high. At the end, a one-clock done pulse marks the turn-off clock. The status outputs (master abort, target stop, completed phase count, latched direction) hold their values until the next start is accepted. Every strobe is driven inactive (high) for at least one clock before the shared output enable drops.

The sequencer is a six-state machine:
- Idle: strobes released.
- Address: FRAME# low, IRDY# high.
- Data: FRAME# and IRDY# both low.
- Last: FRAME# high, IRDY# low.
- Abort: FRAME# high, IRDY# low, entered only on a timeout during Data.
- Turn-off: both strobes driven high.

The transitions are:
- Idle to Address on start.
- Address to Last when one phase is requested, otherwise Address to Data.
- Data to Abort on claim timeout.
- Data to Last when the completion leaves one phase, or when STOP# is seen.
- Last to Turn-off on completion, STOP# or timeout.
- Abort to Turn-off.
- Turn-off to Idle.

Top module: `ibs_initiator`

## Requirements
- R1: After reset, FRAME# and IRDY# are high, the output enable is low, and busy, done, master abort, target stop and the phase count are all zero.
- R2: A start request seen in Idle gives an address clock on the next clock: FRAME# low, IRDY# high, output enable high, busy high. The write flag is latched to the direction output. A start request during a transaction is ignored.
- R3: With more than one phase requested, IRDY# goes low on the clock after the address clock. FRAME# stays low until the clock after the completion that leaves exactly one phase outstanding, and then goes high while IRDY# stays low.
- R4: With a burst length of one, FRAME# goes high on the same clock that IRDY# first goes low. A burst length of zero is treated as one.
- R5: A data phase completes at a clock edge where IRDY# is low, the access is claimed and TRDY# is low. Each completion adds one to the phase count. IRDY# stays low until a completion, a STOP# or an abort ends the phase.
- R6: The claim window is the first five clocks after the address clock. If DEVSEL# is high at all five of those edges, the access ends as a master abort: FRAME# is high on the next clock, IRDY# is high one clock after FRAME#, and the master-abort status is set. DEVSEL# low at the fifth edge avoids the abort.
- R7: Until DEVSEL# has been seen low (at the current edge or earlier), TRDY# and STOP# are ignored: they neither count a phase nor end the access.
- R8: When STOP# is seen low on a claimed access during Data, FRAME# is high on the next clock. The access then ends on the next completion or STOP#. The target-stop status is set, and the phase count reports the phases completed, including one completed on the STOP# clock itself.
- R9: Every access ends with one turn-off clock: both strobes high, output enable high, done high. The output enable is low on the clock after that.
- R10: Master abort, target stop, phase count and direction hold their values from the end of an access until the next start is accepted, which clears the two status flags and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in Idle |
| burst_len_i | input | LEN_W | Requested data phases (0 means 1) |
| write_i | input | 1 | 1 for a write access, 0 for a read |
| devsel_n_i | input | 1 | Target claim, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop request, active low |
| frame_n_o | output | 1 | FRAME# strobe value, active low |
| irdy_n_o | output | 1 | IRDY# strobe value, active low |
| strobe_oe_o | output | 1 | Output enable for both strobes |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-clock pulse in the turn-off clock |
| write_o | output | 1 | Direction latched at start |
| mabort_o | output | 1 | Last access ended by master abort |
| tstop_o | output | 1 | Last access saw STOP# from the target |
| xfer_cnt_o | output | LEN_W | Phases completed in the last access |

## Verification
Two functions can land on the same edge, and each such coincidence is provoked on purpose. In the first, DEVSEL# arrives on the fifth and final edge of the claim window, the edge where the timeout would otherwise fire. The claim must win, and a TRDY# on that same edge must count. Moving DEVSEL# one clock later must turn the access into a master abort with a zero count. In the second, STOP# and TRDY# are low together during Data and again in Last. That phase must be counted and the burst closed on the same edge, with FRAME# high on the next clock. A behavioural model in the bench predicts every strobe, flag and count for each clock, and a hand-worked final status is also checked for each scenario.

// File: rtl/ibs_pkg.sv
package ibs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_LAST = 3'd3,
        ST_MABT = 3'd4,
        ST_TURN = 3'd5
    } seq_state_e;

endpackage

// File: rtl/ibs_claim_timer.sv
module ibs_claim_timer #(
    parameter int WIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic watch_i,
    input  logic devsel_n_i,
    output logic claimed_o,
    output logic expire_o
);
    localparam int CW = $clog2(WIN + 1);
    localparam logic [CW-1:0] LAST_EDGE = CW'(WIN - 1);

    logic [CW-1:0] wait_q;
    logic          claimed_q;

    assign claimed_o = claimed_q;
    assign expire_o  = watch_i && !claimed_q && devsel_n_i && (wait_q == LAST_EDGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q    <= '0;
            claimed_q <= 1'b0;
        end else if (arm_i) begin
            wait_q    <= '0;
            claimed_q <= 1'b0;
        end else if (watch_i && !claimed_q) begin
            if (!devsel_n_i) begin
                claimed_q <= 1'b1;
            end else if (wait_q != LAST_EDGE) begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    // R6
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= LAST_EDGE);

endmodule

// File: rtl/ibs_phase_ctr.sv
module ibs_phase_ctr #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dec_i,
    output logic             rem_one_o,
    output logic             rem_two_o,
    output logic [LEN_W-1:0] done_cnt_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] cnt_q;

    assign rem_one_o  = (rem_q == ONE);
    assign rem_two_o  = (rem_q == TWO);
    assign done_cnt_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            rem_q <= (len_i == '0) ? ONE : len_i;
            cnt_q <= '0;
        end else if (dec_i) begin
            rem_q <= rem_q - 1'b1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    rem_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (rem_q != '0));

endmodule

// File: rtl/ibs_seq_fsm.sv
module ibs_seq_fsm
    import ibs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rem_one_i,
    input  logic       rem_two_i,
    input  logic       expire_i,
    input  logic       xfer_i,
    input  logic       stop_seen_i,
    output seq_state_e state_o,
    output logic       frame_n_o,
    output logic       irdy_n_o,
    output logic       strobe_oe_o,
    output logic       done_o
);
    seq_state_e state_q;
    seq_state_e state_d;

    assign state_o = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_ADDR;
            ST_ADDR: state_d = rem_one_i ? ST_LAST : ST_DATA;
            ST_DATA: begin
                if (expire_i) begin
                    state_d = ST_MABT;
                end else if (stop_seen_i || (xfer_i && rem_two_i)) begin
                    state_d = ST_LAST;
                end
            end
            ST_LAST: if (expire_i || xfer_i || stop_seen_i) state_d = ST_TURN;
            ST_MABT: state_d = ST_TURN;
            ST_TURN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        frame_n_o   = 1'b1;
        irdy_n_o    = 1'b1;
        strobe_oe_o = 1'b1;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: strobe_oe_o = 1'b0;
            ST_ADDR: frame_n_o = 1'b0;
            ST_DATA: begin
                frame_n_o = 1'b0;
                irdy_n_o  = 1'b0;
            end
            ST_LAST: irdy_n_o = 1'b0;
            ST_MABT: irdy_n_o = 1'b0;
            ST_TURN: done_o = 1'b1;
            default: strobe_oe_o = 1'b0;
        endcase
    end

    // R2
    addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n_o) |-> irdy_n_o);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_oe_o) |-> ($past(frame_n_o) && $past(irdy_n_o)));

    // R3
    frame_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n_o && !irdy_n_o) |=> frame_n_o);

endmodule

// File: rtl/ibs_initiator.sv
module ibs_initiator
    import ibs_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int CLAIM_WIN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] burst_len_i,
    input  logic             write_i,
    input  logic             devsel_n_i,
    input  logic             trdy_n_i,
    input  logic             stop_n_i,
    output logic             frame_n_o,
    output logic             irdy_n_o,
    output logic             strobe_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             write_o,
    output logic             mabort_o,
    output logic             tstop_o,
    output logic [LEN_W-1:0] xfer_cnt_o
);
    seq_state_e state;
    logic       in_data;
    logic       load;
    logic       claimed;
    logic       claim_now;
    logic       expire;
    logic       xfer;
    logic       stop_seen;
    logic       rem_one;
    logic       rem_two;
    logic       mabort_q;
    logic       tstop_q;
    logic       write_q;

    assign in_data   = (state == ST_DATA) || (state == ST_LAST);
    assign load      = (state == ST_IDLE) && start_i;
    assign claim_now = claimed || !devsel_n_i;
    assign xfer      = in_data && claim_now && !trdy_n_i;
    assign stop_seen = in_data && claim_now && !stop_n_i;

    ibs_claim_timer #(.WIN(CLAIM_WIN)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (load),
        .watch_i    (in_data),
        .devsel_n_i (devsel_n_i),
        .claimed_o  (claimed),
        .expire_o   (expire)
    );

    ibs_phase_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .len_i      (burst_len_i),
        .dec_i      (xfer),
        .rem_one_o  (rem_one),
        .rem_two_o  (rem_two),
        .done_cnt_o (xfer_cnt_o)
    );

    ibs_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rem_one_i   (rem_one),
        .rem_two_i   (rem_two),
        .expire_i    (expire),
        .xfer_i      (xfer),
        .stop_seen_i (stop_seen),
        .state_o     (state),
        .frame_n_o   (frame_n_o),
        .irdy_n_o    (irdy_n_o),
        .strobe_oe_o (strobe_oe_o),
        .done_o      (done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mabort_q <= 1'b0;
            tstop_q  <= 1'b0;
            write_q  <= 1'b0;
        end else if (load) begin
            mabort_q <= 1'b0;
            tstop_q  <= 1'b0;
            write_q  <= write_i;
        end else begin
            if (expire)    mabort_q <= 1'b1;
            if (stop_seen) tstop_q  <= 1'b1;
        end
    end

    assign mabort_o = mabort_q;
    assign tstop_o  = tstop_q;
    assign write_o  = write_q;
    assign busy_o   = (state != ST_IDLE);

    // R6
    abort_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (frame_n_o && mabort_o));

    // R6
    abort_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && state == ST_DATA) |=> (!irdy_n_o ##1 irdy_n_o));

    // R8
    stop_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (frame_n_o && tstop_o));

    // R4
    single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && rem_one) |=> (frame_n_o && !irdy_n_o));

    // R5
    irdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !xfer && !stop_seen && !expire) |=> !irdy_n_o);

    // R7
    unclaimed_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !claimed && devsel_n_i) |=> $stable(xfer_cnt_o));

endmodule

// File: tb/ibs_initiator_tb_top.sv
module ibs_initiator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] burst_len_i = '0;
    logic          write_i = 1'b0;
    logic          devsel_n_i = 1'b1;
    logic          trdy_n_i = 1'b1;
    logic          stop_n_i = 1'b1;
    logic          frame_n_o, irdy_n_o, strobe_oe_o, busy_o, done_o;
    logic          write_o, mabort_o, tstop_o;
    logic [LW-1:0] xfer_cnt_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit cmp_on = 0;

    // behavioural reference: ph 0 idle,1 address,2 burst,3 final,4 abort,5 release
    int ph = 0, m_rem = 0, m_cnt = 0, m_wait = 0;
    bit m_claim = 0, m_ab = 0, m_ts = 0, m_wr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ibs_initiator #(.LEN_W(LW), .CLAIM_WIN(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .burst_len_i(burst_len_i),
        .write_i(write_i), .devsel_n_i(devsel_n_i), .trdy_n_i(trdy_n_i),
        .stop_n_i(stop_n_i), .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o),
        .strobe_oe_o(strobe_oe_o), .busy_o(busy_o), .done_o(done_o),
        .write_o(write_o), .mabort_o(mabort_o), .tstop_o(tstop_o),
        .xfer_cnt_o(xfer_cnt_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; m_rem = 0; m_cnt = 0; m_wait = 0;
            m_claim = 0; m_ab = 0; m_ts = 0; m_wr = 0;
        end else begin
            bit active, cl, xf, sp, to;
            int old_rem;
            active = (ph == 2) || (ph == 3);
            cl = m_claim || !devsel_n_i;
            xf = active && cl && !trdy_n_i;
            sp = active && cl && !stop_n_i;
            to = active && !cl && (m_wait == 4);
            old_rem = m_rem;
            if (active) begin
                if (!devsel_n_i) m_claim = 1;
                else if (!m_claim && m_wait < 4) m_wait++;
            end
            case (ph)
                0: if (start_i) begin
                    ph = 1; m_rem = (burst_len_i == 0) ? 1 : int'(burst_len_i);
                    m_cnt = 0; m_ab = 0; m_ts = 0; m_claim = 0; m_wait = 0;
                    m_wr = write_i;
                end
                1: ph = (m_rem == 1) ? 3 : 2;
                2, 3: begin
                    if (to) begin
                        m_ab = 1;
                        ph = (ph == 2) ? 4 : 5;
                    end else begin
                        if (xf) begin m_cnt++; m_rem--; end
                        if (sp) m_ts = 1;
                        if (ph == 3) begin
                            if (xf || sp) ph = 5;
                        end else if (sp || (xf && old_rem == 2)) begin
                            ph = 3;
                        end
                    end
                end
                4: ph = 5;
                default: ph = 0;
            endcase
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R3", "frame_n", frame_n_o, (ph == 1 || ph == 2) ? 0 : 1);
            chk("R5", "irdy_n", irdy_n_o, (ph >= 2 && ph <= 4) ? 0 : 1);
            chk("R9", "strobe_oe", strobe_oe_o, (ph != 0) ? 1 : 0);
            chk("R9", "done", done_o, (ph == 5) ? 1 : 0);
            chk("R2", "busy", busy_o, (ph != 0) ? 1 : 0);
            chk("R6", "mabort", mabort_o, m_ab);
            chk("R8", "tstop", tstop_o, m_ts);
            chk("R5", "xfer_cnt", int'(xfer_cnt_o), m_cnt);
            chk("R2", "write", write_o, m_wr);
        end
    end

    // dly: data clock (1..) at which DEVSEL# goes low, 0 = never; tw: wait clocks after claim
    task automatic txn(string tag, int len, bit wr, int dly, int tw, int stop_at,
                       bit stop_data, bit early, bit poke,
                       int e_cnt, bit e_ab, bit e_ts);
        int k;
        @(negedge clk);
        start_i = 1; burst_len_i = LW'(len); write_i = wr;
        devsel_n_i = 1; trdy_n_i = 1; stop_n_i = 1;
        @(negedge clk);
        start_i = 0;
        k = 1;
        while ((ph != 0) && (k < 60)) begin
            bit dv, tr, st;
            dv = (dly > 0) && (k >= 1 + dly);
            tr = dv && ((k - 1 - dly) >= tw);
            st = dv && (m_cnt >= stop_at);
            if (st && !stop_data) tr = 0;
            if (early && !dv) begin tr = 1; st = 1; end
            devsel_n_i = !dv; trdy_n_i = !tr; stop_n_i = !st;
            start_i = poke && (k == 2);
            @(negedge clk);
            k++;
        end
        devsel_n_i = 1; trdy_n_i = 1; stop_n_i = 1; start_i = 0;
        repeat (3) @(negedge clk);
        // status after the access, still held three idle clocks later (R10)
        chk({tag, "/R10"}, "final busy", busy_o, 0);
        chk(tag, "final count", int'(xfer_cnt_o), e_cnt);
        chk(tag, "final mabort", mabort_o, e_ab);
        chk(tag, "final tstop", tstop_o, e_ts);
        chk({tag, "/R2"}, "final write", write_o, wr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "frame_n", frame_n_o, 1);
        chk("R1", "irdy_n", irdy_n_o, 1);
        chk("R1", "strobe_oe", strobe_oe_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "status", {done_o, mabort_o, tstop_o, xfer_cnt_o}, 0);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        txn("R3", 4, 1, 1, 0, 99, 0, 0, 0, 4, 0, 0);
        txn("R4", 1, 0, 2, 1, 99, 0, 0, 0, 1, 0, 0);
        txn("R4", 0, 1, 1, 0, 99, 0, 0, 0, 1, 0, 0);
        txn("R6", 3, 0, 0, 0, 99, 0, 0, 0, 0, 1, 0);
        txn("R7", 1, 1, 0, 0, 99, 0, 1, 0, 0, 1, 0);
        txn("R6", 2, 0, 5, 0, 99, 0, 0, 0, 2, 0, 0);
        txn("R6", 2, 1, 6, 0, 99, 0, 0, 0, 0, 1, 0);
        txn("R7", 2, 0, 3, 0, 99, 0, 1, 0, 2, 0, 0);
        txn("R8", 5, 1, 1, 0, 2, 0, 0, 0, 2, 0, 1);
        txn("R8", 5, 0, 1, 0, 2, 1, 0, 0, 4, 0, 1);
        txn("R8", 2, 1, 1, 0, 1, 1, 0, 0, 2, 0, 1);
        txn("R5", 3, 0, 2, 3, 99, 0, 0, 0, 3, 0, 0);
        txn("R2", 2, 1, 1, 0, 99, 0, 0, 1, 2, 0, 0);
        txn("R3", 15, 0, 4, 2, 99, 0, 0, 0, 15, 0, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule